// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two 32-bit unsigned numbers over several clock cycles, using only one 32-bit adder and one 64-bit working register. A start pulse while the block is idle takes in both operands. The multiplier goes into the low half of the working register and the upper half is cleared. On each clock that follows, the block looks at the lowest bit of the register. If that bit is 1, it adds the multiplicand into the upper half. It then shifts the whole register right by one place.

After 32 such steps the register holds the full 64-bit product. The block drops its busy flag and pulses done for one cycle. The product output shows the working register directly. It therefore holds the final result while the block is idle, until the next accepted start.

The adder's carry-out is kept as a 33rd bit and enters bit 63 during the shift. Large operands therefore lose no part of the result. A start pulse that arrives during an operation is ignored, as are operand changes at that time.

Top module: `seq_shift_mul`

## Requirements
- R1: While reset is held and on the first cycle after it, busy and done are 0 and product is 0.
- R2: A start that is high at a clock edge while busy is 0 is accepted. After that edge, busy is 1 and product equals the multiplier in bits 31:0 with zeros in bits 63:32.
- R3: After an accepted start, busy stays 1 for exactly 32 clock cycles. Done is 1 for exactly one cycle, which is the first cycle in which busy is 0 again.
- R4: In the cycle where done is 1, product equals the unsigned 64-bit product of the two operands captured at the accepted start.
- R5: The carry-out of each step's addition is kept, so all-ones times all-ones gives 0xFFFFFFFE00000001.
- R6: A start pulse while busy is 1 has no effect. The current operation keeps its 32-cycle length and its result.
- R7: While busy is 0 and no start is given, product keeps its value, whatever the operand inputs do.
- R8: Changes to the operand inputs while busy is 1 do not affect the result.
- R9: A start given in the cycle where done is 1 is accepted and begins a new operation at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; acted on only when idle |
| mcand_in | input | 32 | Multiplicand, captured at an accepted start |
| mplier_in | input | 32 | Multiplier, captured at an accepted start |
| busy | output | 1 | High while the 32 add-and-shift steps run |
| done | output | 1 | One-cycle pulse when the product is complete |
| product | output | 64 | Working register; the final product while idle |

## Verification
The assertions assume that start and the operand inputs are stable around each rising clock edge. They also assume that reset is asserted before the first edge, since every property is disabled during reset. The bench changes all inputs only on falling edges and holds reset low for several cycles at the beginning. It deliberately raises start during an operation and changes the operands during an operation, so that the ignore paths and the idle hold property are both exercised and not merely assumed.

// File: rtl/seq_shift_mul.sv
module seq_shift_mul #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   mcand_in,
  input  logic [W-1:0]   mplier_in,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] product
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]   mcand;
  logic [2*W-1:0] acc;
  logic [CW-1:0]  step;
  logic [W:0]     sum;

  // carry kept as bit W, shifted into the top of the register
  assign sum     = {1'b0, acc[2*W-1:W]} + {1'b0, (acc[0] ? mcand : {W{1'b0}})};
  assign product = acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand <= '0;
      acc   <= '0;
      step  <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          acc   <= {{W{1'b0}}, mplier_in};
          mcand <= mcand_in;
          step  <= '0;
          busy  <= 1'b1;
        end
      end else begin
        acc  <= {sum, acc[W-1:1]};
        step <= step + 1'b1;
        if (step == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  AST_LOAD_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && product == {{W{1'b0}}, $past(mplier_in)}); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R3
  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && step != LAST |=> busy && step == $past(step) + 1'b1); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(product)); // R7
  AST_MCAND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mcand)); // R8
endmodule

// File: tb/tb_seq_shift_mul.sv
module tb_seq_shift_mul;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] a = '0;
  logic [31:0] b = '0;
  logic        busy, done;
  logic [63:0] product;

  int errs = 0;
  int checks = 0;

  always #5 clk = ~clk;

  seq_shift_mul #(.W(32)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand_in(a), .mplier_in(b),
    .busy(busy), .done(done), .product(product)
  );

  localparam int NV = 10;
  localparam logic [63:0] VEC [NV] = '{
    {32'h0000_0000, 32'h1234_5678},
    {32'h89AB_CDEF, 32'h0000_0000},
    {32'h0000_0001, 32'hDEAD_BEEF},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {32'hFFFF_FFFF, 32'h0000_0001},
    {32'h8000_0000, 32'h0000_0002},
    {32'h0001_0000, 32'h0001_0000},
    {32'h1234_5678, 32'h9ABC_DEF0},
    {32'hAAAA_AAAA, 32'h5555_5555},
    {32'h0000_0003, 32'h8000_0001}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // starts at a negedge with busy low; returns at the negedge where done is seen
  task automatic run_op(input logic [31:0] x, input logic [31:0] y, input bit poke_start,
                        input bit poke_ops, output int bcnt, output logic [63:0] res);
    a = x; b = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1 && product === {32'h0, y}, "R2 load", product, {32'h0, y});
    bcnt = 0;
    while (!done && bcnt < 100) begin
      if (busy) bcnt++;
      if (poke_start && bcnt == 5) begin a = 32'h7; b = 32'h9; start = 1'b1; end
      else start = 1'b0;
      if (poke_ops && bcnt == 10) begin a = ~x; b = ~y; end
      @(negedge clk);
    end
    start = 1'b0;
    res = product;
  endtask

  initial begin
    #2_000_000;
    errs++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int bc;
    logic [63:0] r, held;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && product === 64'h0, "R1 in reset", product, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && product === 64'h0, "R1 after reset", product, 64'h0);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] x, y;
      x = VEC[i][63:32];
      y = VEC[i][31:0];
      run_op(x, y, 1'b0, 1'b0, bc, r);
      chk(bc == 32, "R3 busy length", 64'(bc), 64'd32);
      chk(busy === 1'b0 && done === 1'b1, "R3 done with idle", {62'h0, busy, done}, 64'h1);
      chk(r === 64'(x) * 64'(y), "R4 product", r, 64'(x) * 64'(y));
      @(negedge clk);
      chk(done === 1'b0, "R3 done single cycle", {63'h0, done}, 64'h0);
    end

    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, bc, r);
    chk(r === 64'hFFFF_FFFE_0000_0001, "R5 carry kept", r, 64'hFFFF_FFFE_0000_0001);
    @(negedge clk);

    // R7: idle hold with wiggling operands
    held = product;
    for (int k = 0; k < 6; k++) begin
      a = 32'h1111_1111 * k; b = ~a;
      @(negedge clk);
      chk(product === held && busy === 1'b0, "R7 idle hold", product, held);
    end

    // R6: start while busy is ignored
    run_op(32'h0BAD_F00D, 32'h0000_1235, 1'b1, 1'b0, bc, r);
    chk(bc == 32, "R6 length unchanged", 64'(bc), 64'd32);
    chk(r === 64'(32'h0BAD_F00D) * 64'(32'h0000_1235), "R6 result unchanged", r,
        64'(32'h0BAD_F00D) * 64'(32'h0000_1235));
    @(negedge clk);
    chk(busy === 1'b0, "R6 no restart", {63'h0, busy}, 64'h0);

    // R8: operand changes mid-run
    run_op(32'hCAFE_0123, 32'h7654_3210, 1'b0, 1'b1, bc, r);
    chk(r === 64'(32'hCAFE_0123) * 64'(32'h7654_3210), "R8 operands ignored", r,
        64'(32'hCAFE_0123) * 64'(32'h7654_3210));

    // R9: start on the done cycle (task returned at the done negedge)
    run_op(32'h0000_FFFF, 32'h0001_0001, 1'b0, 1'b0, bc, r);
    chk(bc == 32 && r === 64'(32'h0000_FFFF) * 64'(32'h0001_0001), "R9 back-to-back", r,
        64'(32'h0000_FFFF) * 64'(32'h0001_0001));
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule